// File: doc/BRIEF.md
# Dish-Control Tone Burst Transmitter

This block sends short command messages to a satellite antenna by switching a nominal 22 kHz tone on and off on one output pin. A host writes between one and eight message bytes into a small store, then writes a control word that gives the byte count and the output form, and that starts the message. Each byte goes out most significant bit first and is followed by an odd-parity bit. Every bit is a fixed number of tone cycles long. The bit value is carried by how long the tone burst lasts within that bit.

The output is either the tone-modulated waveform, which drives the antenna line directly, or the bare on/off envelope, which suits an external tone generator. While a message is in flight the block reports busy. When the message ends, busy drops and a one-clock done pulse marks completion. Between messages the pin holds whatever steady level the control word selects: continuous tone or silence.

Top module: `dish_tone_tx`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `tone_out` are all low.
- R2: Addresses 0 to 7 hold message bytes 0 to 7. Address 8 is the control word: bits [2:0] give the byte count minus one (1 to 8 bytes), bit 3 selects envelope output, bit 4 selects the idle tone, and bit 5 set to 1 starts a message. A message of N bytes keeps `busy` high for exactly N*9*BIT_TONES*2*HALF_DIV clocks, counted from the edge that takes the start write.
- R3: Each bit lasts BIT_TONES tone cycles. A 0 bit is ZERO_TONES cycles of tone followed by silence. A 1 bit is ONE_TONES cycles of tone followed by silence. Bytes are sent in address order, each MSB first, and each is followed by a ninth bit that makes the count of ones in the nine bits odd.
- R4: With control bit 3 clear, a burst is a square wave with a period of 2*HALF_DIV clocks. The wave is high for the first HALF_DIV clocks of each tone cycle, and the tone cycles are aligned to the start edge. `tone_out` is registered and lags the internal state by one clock.
- R5: With control bit 3 set, `tone_out` stays high for the whole of each burst and low during the silences.
- R6: A control write while `busy` is high has no effect. The running message keeps its waveform, byte count and end time.
- R7: At the end of the last parity bit, `busy` falls and `done` is high for exactly one clock.
- R8: While idle, control bit 4 set gives a continuous tone: a square wave with a period of 2*HALF_DIV clocks, or steady high in envelope mode. Bit 4 clear gives a steady low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register address: 0..7 message bytes, 8 control |
| wr_data | input | 8 | Register write data |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-clock pulse at the end of a message |
| tone_out | output | 1 | Tone or envelope output to the antenna line |

## Verification
Take the edge that accepts a start write as clock zero. The state at clock m then sets `tone_out` at clock m+1, because the output register adds one clock of lag. `busy` is high from clock 0, and `done` is high at exactly clock N*9*BIT_TONES*2*HALF_DIV. The bench samples every signal on the falling edge after each rising edge. It computes the tone-cycle index, the position within the half period, the bit and the byte from m alone, and compares every cycle of every message for lengths 1 to 8 in both output forms. In the ignored-start case, a control write is injected mid-message and the bench expects the same waveform and end time as an undisturbed message.

// File: rtl/dish_tone_pkg.sv
package dish_tone_pkg;
  localparam int CTL_LEN_LSB   = 0;
  localparam int CTL_ENV_BIT   = 3;
  localparam int CTL_IDLE_BIT  = 4;
  localparam int CTL_START_BIT = 5;
  localparam int BYTE_BITS     = 8;
  localparam int FRAME_BITS    = BYTE_BITS + 1;

  function automatic logic odd_parity(input logic [BYTE_BITS-1:0] d);
    return ~(^d);
  endfunction
endpackage

// File: rtl/dish_tone_div.sv
module dish_tone_div #(
  parameter int HALF_DIV = 4545
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic phase,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == LAST) && !phase;

  // R4: one tone cycle ends at most once per two clocks
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/dish_tone_store.sv
module dish_tone_store #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dish_tone_seq.sv
module dish_tone_seq
  import dish_tone_pkg::*;
#(
  parameter int IDX_W      = 3,
  parameter int BIT_TONES  = 33,
  parameter int ZERO_TONES = 22,
  parameter int ONE_TONES  = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [IDX_W-1:0] len_m1,
  input  logic             tick,
  input  logic [7:0]       cur_byte,
  output logic [IDX_W-1:0] byte_idx,
  output logic             busy,
  output logic             done,
  output logic             envelope
);
  localparam int TW = $clog2(BIT_TONES);
  localparam logic [TW-1:0] T_LAST = TW'(BIT_TONES - 1);
  localparam logic [TW-1:0] T_ZERO = TW'(ZERO_TONES);
  localparam logic [TW-1:0] T_ONE  = TW'(ONE_TONES);
  localparam logic [3:0]    B_LAST = 4'(FRAME_BITS - 1);

  logic [TW-1:0] tone_cnt;
  logic [3:0]    bit_idx;
  logic          bit_val;

  always_comb begin
    if (bit_idx == B_LAST) bit_val = odd_parity(cur_byte);
    else                   bit_val = cur_byte[3'(7 - bit_idx)];
  end

  assign envelope = busy && (tone_cnt < (bit_val ? T_ONE : T_ZERO));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      byte_idx <= '0;
      bit_idx  <= '0;
      tone_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy     <= 1'b1;
        byte_idx <= '0;
        bit_idx  <= '0;
        tone_cnt <= '0;
      end else if (busy && tick) begin
        if (tone_cnt != T_LAST) begin
          tone_cnt <= tone_cnt + 1'b1;
        end else begin
          tone_cnt <= '0;
          if (bit_idx != B_LAST) begin
            bit_idx <= bit_idx + 1'b1;
          end else begin
            bit_idx <= '0;
            if (byte_idx == len_m1) begin
              busy     <= 1'b0;
              done     <= 1'b1;
              byte_idx <= '0;
            end else begin
              byte_idx <= byte_idx + 1'b1;
            end
          end
        end
      end
    end
  end

  // R7: done is a single-clock pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7: busy only falls together with done
  p_busy_fall_done_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R3: tone counter stays inside one bit
  p_tone_range_r3: assert property (@(posedge clk) disable iff (rst)
    tone_cnt <= T_LAST);
  // R2: byte index never passes the programmed count
  p_len_bound_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> byte_idx <= len_m1);
endmodule

// File: rtl/dish_tone_tx.sv
module dish_tone_tx
  import dish_tone_pkg::*;
#(
  parameter int HALF_DIV   = 4545,
  parameter int BIT_TONES  = 33,
  parameter int ZERO_TONES = 22,
  parameter int ONE_TONES  = 11,
  parameter int MAX_BYTES  = 8,
  parameter int IDX_W      = $clog2(MAX_BYTES),
  parameter int ADDR_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              busy,
  output logic              done,
  output logic              tone_out
);
  logic             ctl_sel, byte_we, start_req, launch;
  logic [IDX_W-1:0] len_m1, byte_idx;
  logic             env_mode, idle_on;
  logic             phase, tick, envelope;
  logic [7:0]       cur_byte;

  assign ctl_sel   = wr_en && wr_addr[ADDR_W-1];
  assign byte_we   = wr_en && !wr_addr[ADDR_W-1];
  assign start_req = ctl_sel && wr_data[CTL_START_BIT];
  assign launch    = start_req && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_m1   <= '0;
      env_mode <= 1'b0;
      idle_on  <= 1'b0;
    end else if (ctl_sel && !busy) begin
      len_m1   <= wr_data[CTL_LEN_LSB +: IDX_W];
      env_mode <= wr_data[CTL_ENV_BIT];
      idle_on  <= wr_data[CTL_IDLE_BIT];
    end
  end

  dish_tone_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .restart(launch), .phase(phase), .tick(tick)
  );

  dish_tone_store #(.DEPTH(MAX_BYTES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .we(byte_we), .waddr(wr_addr[IDX_W-1:0]), .wdata(wr_data),
    .raddr(byte_idx), .rdata(cur_byte)
  );

  dish_tone_seq #(
    .IDX_W(IDX_W), .BIT_TONES(BIT_TONES),
    .ZERO_TONES(ZERO_TONES), .ONE_TONES(ONE_TONES)
  ) u_seq (
    .clk(clk), .rst(rst), .launch(launch),
    .len_m1(wr_data[CTL_LEN_LSB +: IDX_W] & {IDX_W{launch}} | len_m1 & {IDX_W{!launch}}),
    .tick(tick), .cur_byte(cur_byte), .byte_idx(byte_idx),
    .busy(busy), .done(done), .envelope(envelope)
  );

  always_ff @(posedge clk) begin
    if (rst)       tone_out <= 1'b0;
    else if (busy) tone_out <= envelope && (env_mode || phase);
    else           tone_out <= idle_on && (env_mode || phase);
  end

  // R8: idle with tone disabled drives a steady low
  p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !idle_on) |=> !tone_out);
  // R6: a start request during a message does not relaunch it
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && start_req && !tick) |=> busy);
endmodule

// File: tb/tb_dish_tone_tx.sv
`timescale 1ns/100ps
module tb_dish_tone_tx;
  localparam int H  = 2;
  localparam int BT = 33;
  localparam int ZT = 22;
  localparam int OT = 11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       busy, done, tone_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] msg [8];

  always #2.5 clk = ~clk;

  dish_tone_tx #(.HALF_DIV(H), .BIT_TONES(BT), .ZERO_TONES(ZT), .ONE_TONES(OT)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .tone_out(tone_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  function automatic logic exp_out(int k, int total, logic envm);
    int g, p, b, tc, by, bp, on;
    logic bv;
    if (k >= total) return 1'b0;
    g = k / (2*H); p = k % (2*H);
    b = g / BT; tc = g % BT; by = b / 9; bp = b % 9;
    bv = (bp < 8) ? msg[by][7-bp] : ~(^msg[by]);
    on = bv ? OT : ZT;
    return (tc < on) && (envm || (p < H));
  endfunction

  task automatic run_msg(input int n, input logic envm, input int inject_m, input string req);
    int total, e_out, e_busy, e_done;
    total = n * 9 * BT * 2 * H;
    e_out = 0; e_busy = 0; e_done = 0;
    for (int i = 0; i < n; i++) begin
      msg[i] = 8'(i*37 + n*11 + 8'h5A);
      if (n == 2) msg[i] = (i == 0) ? 8'h00 : 8'hFF;
      wr(4'(i), msg[i]);
    end
    wr(4'd8, {2'b00, 1'b1, 1'b0, envm, 3'(n-1)});
    for (int m = 0; m <= total + 1; m++) begin
      @(negedge clk);
      if (wr_en) wr_en = 1'b0;
      if (busy != (m < total)) e_busy++;
      if (done != (m == total)) e_done++;
      if (m >= 1 && tone_out != exp_out(m-1, total, envm)) e_out++;
      if (m == inject_m) begin
        wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'h2F;
      end
    end
    check({req, " waveform mismatches"}, e_out, 0);
    check("R2 busy length", e_busy, 0);
    check("R7 done pulse", e_done, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int edges;
    logic prev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    check("R1 tone_out reset", tone_out, 0);
    rst = 1'b0;
    // modulated form, every length
    for (int n = 1; n <= 8; n++) run_msg(n, 1'b0, -1, "R3 R4");
    // envelope form
    run_msg(1, 1'b1, -1, "R5");
    run_msg(3, 1'b1, -1, "R5");
    run_msg(8, 1'b1, -1, "R5");
    // control write mid-message ignored
    run_msg(2, 1'b0, 500, "R6");
    run_msg(1, 1'b1, 100, "R6");
    // idle levels
    wr(4'd8, 8'h18);
    repeat (2) @(negedge clk);
    check("R8 idle envelope high", tone_out, 1);
    wr(4'd8, 8'h10);
    repeat (2) @(negedge clk);
    prev = tone_out; edges = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tone_out != prev) edges++;
      prev = tone_out;
    end
    check("R8 idle tone toggles", edges, 40 / H);
    wr(4'd8, 8'h00);
    repeat (2) @(negedge clk);
    check("R8 idle off low", tone_out, 0);
    check("R7 idle busy low", busy, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule